// File: doc/BRIEF.md
# Command List Sequencer

This block walks a list of 64-bit commands held in memory and carries out each one without help from a host processor. Every command occupies two 32-bit memory words on an 8-byte boundary. The low word carries a 4-bit opcode in bits [31:28] and an address or offset in bits [27:0]. The high word carries a data or parameter field. The block reads words one at a time through a simple valid/ready read port. It issues register writes on a master port that is always accepted. It can hold off on a hardware status vector, branch on a condition word, call one level of subroutine, and raise an interrupt when the list finishes.

Software controls the block through a 32-bit control word. Bit 31 is the start flag, bit 30 reads back as idle, and bits [27:0] hold the program counter. Writing the word with the start flag set while the block is idle loads the counter and begins fetching. Writing it with the start flag clear lets the command in progress complete, then parks the block. The counter then points at the next command, or at a status-test command that was still waiting. Resuming means writing that same address back with the start flag set.

Top module: `cmd_list_seq`

## Requirements
- R1: After reset the control word reads 0x40000000 (idle set, start clear, address 0), and no read, register write, interrupt or error is asserted.
- R2: A control write with bit 31 set while idle loads the program counter from bits [27:0] with bits [2:0] forced to zero. Each command is fetched as two reads, the low word at the counter and the high word at counter+4, with at most one read outstanding.
- R3: Opcode 0x1 issues one register write of the high word to the register address in low-word bits [20:0], with bits [1:0] cleared, and then continues at counter+8.
- R4: Opcode 0x3 takes a count N from the high word. It reads the N words that follow the command and writes them to consecutive register addresses starting at the address in bits [20:0]. When N is odd, the padding word is skipped without being read, and the next command is at counter+8+4N rounded up to a multiple of 8. N=0 writes nothing.
- R5: Opcode 0x6 waits, issuing nothing, until (status & mask) equals (value & mask). The mask is low-word bits [20:0] and the value is high-word bits [20:0]. It then continues at counter+8.
- R6: Opcode 0x8 clears start, sets idle and leaves the counter at counter+8. If low-word bit 0 is set and the interrupt enable input is high, it pulses the interrupt for one cycle.
- R7: Opcode 0x9 jumps to the address in bits [27:0]. If high-word bit 0 is set, the target is instead that field added, as a signed 28-bit value, to the counter of the jump command.
- R8: Opcode 0xB stores counter+8 as the return address and jumps as in R7. Opcode 0xA jumps to the stored return address.
- R9: Opcode 0xC branches to counter+8 plus the signed field in bits [27:0] when the high word AND the condition input is nonzero, and otherwise goes to counter+8. Low word 0xC0000000 with high word 0 is therefore a no-op.
- R10: A control write with bit 31 clear stops the block once the current command ends, or at once while a status test waits, in which case the counter stays on the test. While idle, the counter does not change without a start write. Writing the parked address back with bit 31 set resumes execution there.
- R11: Opcodes 0x0, 0x2, 0x4, 0x5, 0x7, 0xD, 0xE and 0xF set the sticky error output, clear start and go idle with the counter on the offending command, and do not interrupt. The next start write clears the error.
- R12: While a command list runs, the control word reads idle clear, start set, and the address of the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 32 | Control word write value (bit 31 start, bits [27:0] address) |
| ctlRdData | output | 32 | Control word read value (bit 31 start, bit 30 idle, bits [27:0] counter) |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request accepted |
| memReqAddr | output | 28 | Byte address of the 32-bit word to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| regWrValid | output | 1 | Register write strobe |
| regWrAddr | output | 21 | Register byte address |
| regWrData | output | 32 | Register write data |
| hwStatus | input | 21 | Hardware status vector for status tests |
| condReg | input | 32 | Condition word for conditional branches |
| irqEnable | input | 1 | Interrupt mask (1 lets the finish interrupt through) |
| irq | output | 1 | One-cycle finish interrupt pulse |
| cmdErr | output | 1 | Sticky unimplemented-opcode flag |

## Verification
Register writes from opcode 0x1 appear in the cycle after the high-word response arrives. Each immediate write appears in the cycle its data word returns, and the finish interrupt pulses in that same execute cycle. The bench records every write and interrupt at the falling edge of every cycle, so its checks compare whole ordered sequences rather than guessing single cycles, and it reads the final control word only after polling idle within a bounded wait. Stalls and stops are checked over fixed windows of 10 to 30 cycles, during which write counts and the parked address must not move. Mid-run stops are checked against any prefix of the expected write order, since the exact stop point varies by a command.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

  localparam logic [3:0] OP_LDREG = 4'h1;
  localparam logic [3:0] OP_LDIMM = 4'h3;
  localparam logic [3:0] OP_STAT  = 4'h6;
  localparam logic [3:0] OP_FIN   = 4'h8;
  localparam logic [3:0] OP_GOTO  = 4'h9;
  localparam logic [3:0] OP_RET   = 4'hA;
  localparam logic [3:0] OP_GOSUB = 4'hB;
  localparam logic [3:0] OP_CJMP  = 4'hC;

  typedef enum logic [3:0] {
    S_IDLE, S_FLO, S_WLO, S_FHI, S_WHI, S_EXEC, S_STAT, S_IREQ, S_IWAIT
  } seqState_t;

  typedef enum logic [1:0] {MS_LO, MS_HI, MS_IMM} memSel_t;

  typedef enum logic [2:0] {
    PC_HOLD, PC_CTL, PC_NEXT, PC_GO, PC_CJ, PC_RET, PC_IMMEND
  } pcSel_t;

  // strobes from control to datapath
  typedef struct packed {
    pcSel_t  pcSel;
    memSel_t memSel;
    logic    capLo;
    logic    capHi;
    logic    saveRet;
    logic    immInit;
    logic    immStep;
    logic    wrImm;
  } dpCtl_t;

endpackage

// File: rtl/cmdl_dp.sv
module cmdl_dp
  import cmdl_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int STAT_W  = 21,
  parameter int RADDR_W = 21,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [ADDR_W-1:0]  ctlAddr,
  input  logic [31:0]        memRspData,
  input  logic [STAT_W-1:0]  hwStatus,
  input  logic [31:0]        condReg,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [RADDR_W-1:0] regWrAddr,
  output logic [31:0]        regWrData,
  output logic [3:0]         opcode,
  output logic               finIrqBit,
  output logic               statusMatch,
  output logic               immDone
);

  localparam logic [ADDR_W-1:0]  STEP_CMD  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0]  STEP_WORD = ADDR_W'(4);
  localparam logic [RADDR_W-1:0] STEP_REG  = RADDR_W'(4);

  logic [ADDR_W-1:0]  retAddr, immPtr;
  logic [31:0]        cmdLo, cmdHi;
  logic [CNT_W-1:0]   immLeft;
  logic [RADDR_W-1:0] regPtr;

  logic [ADDR_W-1:0]  fieldAddr, nextPc, goTarget, cjTarget, immEnd;
  logic [RADDR_W-1:0] cmdRegAddr;
  logic               condHit;

  function automatic logic [ADDR_W-1:0] align8(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:3], 3'b000};
  endfunction

  assign opcode      = cmdLo[31:28];
  assign finIrqBit   = cmdLo[0];
  assign fieldAddr   = cmdLo[ADDR_W-1:0];
  assign cmdRegAddr  = {cmdLo[RADDR_W-1:2], 2'b00};
  assign nextPc      = pc + STEP_CMD;
  assign goTarget    = align8(cmdHi[0] ? (pc + fieldAddr) : fieldAddr);
  assign condHit     = |(cmdHi & condReg);
  assign cjTarget    = condHit ? align8(nextPc + fieldAddr) : nextPc;
  assign immEnd      = immPtr[2] ? (immPtr + STEP_WORD) : immPtr;
  assign statusMatch = ((hwStatus ^ cmdHi[STAT_W-1:0]) & cmdLo[STAT_W-1:0]) == '0;
  assign immDone     = (immLeft == '0);

  always_comb begin
    unique case (ctl.memSel)
      MS_HI:   memAddr = pc + STEP_WORD;
      MS_IMM:  memAddr = immPtr;
      default: memAddr = pc;
    endcase
  end

  assign regWrAddr = ctl.wrImm ? regPtr : cmdRegAddr;
  assign regWrData = ctl.wrImm ? memRspData : cmdHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      retAddr <= '0;
      cmdLo   <= '0;
      cmdHi   <= '0;
      immPtr  <= '0;
      immLeft <= '0;
      regPtr  <= '0;
    end else begin
      unique case (ctl.pcSel)
        PC_CTL:    pc <= align8(ctlAddr);
        PC_NEXT:   pc <= nextPc;
        PC_GO:     pc <= goTarget;
        PC_CJ:     pc <= cjTarget;
        PC_RET:    pc <= retAddr;
        PC_IMMEND: pc <= immEnd;
        default:   pc <= pc;
      endcase
      if (ctl.capLo)   cmdLo   <= memRspData;
      if (ctl.capHi)   cmdHi   <= memRspData;
      if (ctl.saveRet) retAddr <= nextPc;
      if (ctl.immInit) begin
        immPtr  <= nextPc;
        immLeft <= cmdHi[CNT_W-1:0];
        regPtr  <= cmdRegAddr;
      end else if (ctl.immStep) begin
        immPtr  <= immPtr + STEP_WORD;
        immLeft <= immLeft - CNT_W'(1);
        regPtr  <= regPtr + STEP_REG;
      end
    end
  end

  // R4: a data word is only consumed while the count is still positive
  assert_imm_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.immStep |-> !immDone)
    else $error("immediate step with zero count");

endmodule

// File: rtl/cmdl_ctrl.sv
module cmdl_ctrl
  import cmdl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       ctlWrStart,
  input  logic [3:0] opcode,
  input  logic       finIrqBit,
  input  logic       statusMatch,
  input  logic       immDone,
  input  logic       irqEnable,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output dpCtl_t     ctl,
  output logic       memReqValid,
  output logic       regWrValid,
  output logic       irq,
  output logic       idle,
  output logic       startBit,
  output logic       cmdErr
);

  seqState_t state, nxt;
  logic      startNext, errNext, startEff;
  seqState_t boundaryNext;

  assign idle         = (state == S_IDLE);
  assign startEff     = ctlWrEn ? ctlWrStart : startBit;
  assign boundaryNext = startEff ? S_FLO : S_IDLE;

  always_comb begin
    nxt         = state;
    ctl         = '0;
    memReqValid = 1'b0;
    regWrValid  = 1'b0;
    irq         = 1'b0;
    startNext   = startBit;
    errNext     = cmdErr;
    if (ctlWrEn && state != S_IDLE) startNext = ctlWrStart;

    unique case (state)
      S_IDLE: begin
        if (ctlWrEn && ctlWrStart) begin
          ctl.pcSel = PC_CTL;
          startNext = 1'b1;
          errNext   = 1'b0;
          nxt       = S_FLO;
        end
      end
      S_FLO: begin
        memReqValid = 1'b1;
        ctl.memSel  = MS_LO;
        if (memReqReady) nxt = S_WLO;
      end
      S_WLO: begin
        if (memRspValid) begin
          ctl.capLo = 1'b1;
          nxt       = S_FHI;
        end
      end
      S_FHI: begin
        memReqValid = 1'b1;
        ctl.memSel  = MS_HI;
        if (memReqReady) nxt = S_WHI;
      end
      S_WHI: begin
        if (memRspValid) begin
          ctl.capHi = 1'b1;
          nxt       = S_EXEC;
        end
      end
      S_EXEC: begin
        case (opcode)
          OP_LDREG: begin
            regWrValid = 1'b1;
            ctl.pcSel  = PC_NEXT;
            nxt        = boundaryNext;
          end
          OP_LDIMM: begin
            ctl.immInit = 1'b1;
            nxt         = S_IREQ;
          end
          OP_STAT: nxt = S_STAT;
          OP_FIN: begin
            ctl.pcSel = PC_NEXT;
            startNext = 1'b0;
            irq       = finIrqBit & irqEnable;
            nxt       = S_IDLE;
          end
          OP_GOTO: begin
            ctl.pcSel = PC_GO;
            nxt       = boundaryNext;
          end
          OP_GOSUB: begin
            ctl.saveRet = 1'b1;
            ctl.pcSel   = PC_GO;
            nxt         = boundaryNext;
          end
          OP_RET: begin
            ctl.pcSel = PC_RET;
            nxt       = boundaryNext;
          end
          OP_CJMP: begin
            ctl.pcSel = PC_CJ;
            nxt       = boundaryNext;
          end
          default: begin
            errNext   = 1'b1;
            startNext = 1'b0;
            nxt       = S_IDLE;
          end
        endcase
      end
      S_STAT: begin
        if (statusMatch) begin
          ctl.pcSel = PC_NEXT;
          nxt       = boundaryNext;
        end else if (!startEff) begin
          nxt = S_IDLE;
        end
      end
      S_IREQ: begin
        ctl.memSel = MS_IMM;
        if (immDone) begin
          ctl.pcSel = PC_IMMEND;
          nxt       = boundaryNext;
        end else begin
          memReqValid = 1'b1;
          if (memReqReady) nxt = S_IWAIT;
        end
      end
      S_IWAIT: begin
        ctl.memSel = MS_IMM;
        if (memRspValid) begin
          regWrValid  = 1'b1;
          ctl.wrImm   = 1'b1;
          ctl.immStep = 1'b1;
          nxt         = S_IREQ;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      startBit <= 1'b0;
      cmdErr   <= 1'b0;
    end else begin
      state    <= nxt;
      startBit <= startNext;
      cmdErr   <= errNext;
    end
  end

  // R6: the finish interrupt is a single pulse and leaves the block idle
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> (idle && !irq))
    else $error("interrupt not a single pulse into idle");

  // R11: raising the error flag coincides with halting
  assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> (idle && !startBit))
    else $error("error raised without halting");

endmodule

// File: rtl/cmd_list_seq.sv
module cmd_list_seq
  import cmdl_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int STAT_W  = 21,
  parameter int RADDR_W = 21,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic [31:0]        ctlWrData,
  output logic [31:0]        ctlRdData,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  output logic               regWrValid,
  output logic [RADDR_W-1:0] regWrAddr,
  output logic [31:0]        regWrData,
  input  logic [STAT_W-1:0]  hwStatus,
  input  logic [31:0]        condReg,
  input  logic               irqEnable,
  output logic               irq,
  output logic               cmdErr
);

  localparam int IDLE_BIT  = 30;
  localparam int START_BIT = 31;

  dpCtl_t            ctl;
  logic [ADDR_W-1:0] pc;
  logic [3:0]        opcode;
  logic              finIrqBit, statusMatch, immDone, idle, startBit;
  logic              unusedCtl;

  assign unusedCtl = ^ctlWrData[IDLE_BIT:ADDR_W];

  cmdl_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctlWrEn     (ctlWrEn),
    .ctlWrStart  (ctlWrData[START_BIT]),
    .opcode      (opcode),
    .finIrqBit   (finIrqBit),
    .statusMatch (statusMatch),
    .immDone     (immDone),
    .irqEnable   (irqEnable),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .regWrValid  (regWrValid),
    .irq         (irq),
    .idle        (idle),
    .startBit    (startBit),
    .cmdErr      (cmdErr)
  );

  cmdl_dp #(
    .ADDR_W  (ADDR_W),
    .STAT_W  (STAT_W),
    .RADDR_W (RADDR_W),
    .CNT_W   (CNT_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .ctlAddr     (ctlWrData[ADDR_W-1:0]),
    .memRspData  (memRspData),
    .hwStatus    (hwStatus),
    .condReg     (condReg),
    .pc          (pc),
    .memAddr     (memReqAddr),
    .regWrAddr   (regWrAddr),
    .regWrData   (regWrData),
    .opcode      (opcode),
    .finIrqBit   (finIrqBit),
    .statusMatch (statusMatch),
    .immDone     (immDone)
  );

  always_comb begin
    ctlRdData             = '0;
    ctlRdData[ADDR_W-1:0] = pc;
    ctlRdData[IDLE_BIT]   = idle;
    ctlRdData[START_BIT]  = startBit;
  end

  // tracks an accepted read whose data has not yet returned
  logic rdPending;
  always_ff @(posedge clk) begin
    if (!rstN)                            rdPending <= 1'b0;
    else if (memReqValid && memReqReady)  rdPending <= 1'b1;
    else if (memRspValid)                 rdPending <= 1'b0;
  end

  // R2: never a second read while one is outstanding
  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !rdPending)
    else $error("second read issued while one is in flight");

  // R2: word reads stay 4-byte aligned
  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00))
    else $error("misaligned read");

  // R12: an idle block issues no traffic
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[IDLE_BIT] |-> (!memReqValid && !regWrValid))
    else $error("traffic while idle");

  // R10: parked counter stays put without a control write
  assert_idle_pc_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[IDLE_BIT] && !ctlWrEn) |=> $stable(ctlRdData[ADDR_W-1:0]))
    else $error("counter moved while idle");

endmodule

// File: tb/cmd_list_seq_test.sv
module cmd_list_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic        memReqValid;
  logic        memReqReady;
  logic [27:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        regWrValid;
  logic [20:0] regWrAddr;
  logic [31:0] regWrData;
  logic [20:0] hwStatus = '0;
  logic [31:0] condReg = '0;
  logic        irqEnable = 1'b0;
  logic        irq;
  logic        cmdErr;

  always #5 clk = ~clk;

  cmd_list_seq uut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .hwStatus(hwStatus), .condReg(condReg), .irqEnable(irqEnable),
    .irq(irq), .cmdErr(cmdErr)
  );

  // memory model: one-cycle read latency, optional toggling ready
  logic [31:0] mem [0:511];
  logic        toggleReady = 1'b0;
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspData  <= '0;
      memReqReady <= 1'b1;
    end else begin
      memRspValid <= memReqValid && memReqReady;
      memRspData  <= mem[memReqAddr[10:2]];
      memReqReady <= toggleReady ? ~memReqReady : 1'b1;
    end
  end

  // observers sampled away from the active edge
  logic [31:0] logA [0:63];
  logic [31:0] logD [0:63];
  int logN = 0, irqN = 0, reqN = 0;
  logic [31:0] reqA [0:3];
  always @(negedge clk) begin
    if (rstN && regWrValid && logN < 64) begin
      logA[logN] = {11'd0, regWrAddr};
      logD[logN] = regWrData;
      logN++;
    end
    if (rstN && irq) irqN++;
    if (rstN && memReqValid && memReqReady) begin
      if (reqN < 4) reqA[reqN] = {4'd0, memReqAddr};
      reqN++;
    end
  end

  int compN = 0, failN = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compN++;
    if (act !== exp) begin
      failN++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putCmd(input int addr, input logic [31:0] lo, input logic [31:0] hi);
    mem[addr >> 2]       = lo;
    mem[(addr >> 2) + 1] = hi;
  endtask

  task automatic ctlWrite(input logic [31:0] d);
    @(negedge clk);
    ctlWrEn   = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn   = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 3000; k++) begin
      if (ctlRdData[30]) break;
      @(negedge clk);
    end
  endtask

  task automatic clearLogs();
    logN = 0; irqN = 0; reqN = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compN, failN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failN++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    // program A: load register and immediate bursts
    putCmd('h000, 32'h1000_0103, 32'hDEAD_BEEF);
    putCmd('h008, 32'h3000_0200, 32'd3);
    for (int i = 0; i < 3; i++) mem[('h010 >> 2) + i] = 32'hC0DE_0000 + i;
    mem['h01C >> 2] = 32'hFFFF_FFFF;
    putCmd('h020, 32'h3000_0300, 32'd2);
    for (int i = 0; i < 2; i++) mem[('h028 >> 2) + i] = 32'hF00D_0000 + i;
    putCmd('h030, 32'h3000_0400, 32'd0);
    putCmd('h038, 32'h8000_0001, 32'd0);
    // program B: jumps, call/return, conditional branches
    putCmd('h100, 32'h9000_0140, 32'd0);
    putCmd('h108, 32'h1000_BAD0, 32'hBAD0_0001);
    putCmd('h118, 32'h1000_0308, 32'h3333_3333);
    putCmd('h120, 32'h8000_0000, 32'd0);
    putCmd('h140, 32'hB000_0040, 32'd1);
    putCmd('h148, 32'hC000_0010, 32'h0000_0F00);
    putCmd('h150, 32'hC000_0000, 32'd0);
    putCmd('h158, 32'h1000_BAD8, 32'hBAD0_0002);
    putCmd('h160, 32'hC000_0020, 32'h0000_00F0);
    putCmd('h168, 32'hC000_0000, 32'd0);
    putCmd('h170, 32'h9FFF_FFA8, 32'd1);
    putCmd('h180, 32'h1000_0300, 32'h1111_1111);
    putCmd('h188, 32'h9000_0018, 32'd1);
    putCmd('h190, 32'h1000_BA90, 32'hBAD0_0003);
    putCmd('h1A0, 32'h1000_0304, 32'h2222_2222);
    putCmd('h1A8, 32'hA000_0000, 32'd0);
    // program C: status wait
    putCmd('h200, 32'h6000_0005, 32'h0000_0004);
    putCmd('h208, 32'h1000_0400, 32'hA5A5_A5A5);
    putCmd('h210, 32'h8000_0001, 32'd0);
    // program D: bad opcode
    putCmd('h280, 32'h1000_0500, 32'd1);
    putCmd('h288, 32'h7000_0000, 32'd0);
    putCmd('h290, 32'h8000_0000, 32'd0);
    // program E: long run for stop/resume
    for (int i = 0; i < 8; i++)
      putCmd('h300 + 8 * i, 32'h1000_0600 + 4 * i, 32'h0101_0101 * (i + 1));
    putCmd('h340, 32'h8000_0000, 32'd0);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctl", ctlRdData, 32'h4000_0000);
    chk("R1 outs", {28'd0, memReqValid, regWrValid, irq, cmdErr}, 32'd0);

    // program A with toggling ready
    toggleReady = 1'b1; irqEnable = 1'b1; clearLogs();
    ctlWrite(32'h8000_0005);
    waitIdle();
    chk("R2 first read", reqA[0], 32'h000);
    chk("R2 second read", reqA[1], 32'h004);
    chk("R4 read count", reqN, 32'd15);
    chk("R3/R4 write count", logN, 32'd6);
    chk("R3 addr", logA[0], 32'h100);
    chk("R3 data", logD[0], 32'hDEAD_BEEF);
    for (int i = 0; i < 3; i++) begin
      chk("R4 odd addr", logA[1 + i], 32'h200 + 4 * i);
      chk("R4 odd data", logD[1 + i], 32'hC0DE_0000 + i);
    end
    for (int i = 0; i < 2; i++) begin
      chk("R4 even addr", logA[4 + i], 32'h300 + 4 * i);
      chk("R4 even data", logD[4 + i], 32'hF00D_0000 + i);
    end
    chk("R6 irq", irqN, 32'd1);
    chk("R6 final ctl", ctlRdData, 32'h4000_0040);

    // R6 masked interrupt
    irqEnable = 1'b0; clearLogs();
    ctlWrite(32'h8000_0038);
    waitIdle();
    chk("R6 masked irq", irqN, 32'd0);
    chk("R6 masked ctl", ctlRdData, 32'h4000_0040);

    // program B: R7 R8 R9
    toggleReady = 1'b0; condReg = 32'h0000_0100; clearLogs();
    ctlWrite(32'h8000_0100);
    waitIdle();
    chk("R7/R8/R9 write count", logN, 32'd3);
    chk("R8 sub addr0", logA[0], 32'h300);
    chk("R8 sub data0", logD[0], 32'h1111_1111);
    chk("R7 rel target addr", logA[1], 32'h304);
    chk("R7 neg target addr", logA[2], 32'h308);
    chk("R9 path data", logD[2], 32'h3333_3333);
    chk("R7 final ctl", ctlRdData, 32'h4000_0128);

    // program C: R5 R10 R12
    irqEnable = 1'b1; hwStatus = '0; clearLogs();
    ctlWrite(32'h8000_0200);
    repeat (30) @(negedge clk);
    chk("R5 stall writes", logN, 32'd0);
    chk("R12 running ctl", ctlRdData, 32'h8000_0200);
    hwStatus = 21'h5;
    repeat (20) @(negedge clk);
    chk("R5 partial match stall", logN, 32'd0);
    ctlWrite(32'h0000_0000);
    waitIdle();
    chk("R10 parked on test", ctlRdData, 32'h4000_0200);
    hwStatus = 21'h6;
    repeat (10) @(negedge clk);
    chk("R10 stays parked", ctlRdData, 32'h4000_0200);
    chk("R10 no writes parked", logN, 32'd0);
    ctlWrite(32'h8000_0200);
    waitIdle();
    chk("R5 released write", logN, 32'd1);
    chk("R5 released addr", logA[0], 32'h400);
    chk("R5 released data", logD[0], 32'hA5A5_A5A5);
    chk("R6 irq after resume", irqN, 32'd1);
    chk("R5 final ctl", ctlRdData, 32'h4000_0218);

    // program D: R11
    clearLogs();
    ctlWrite(32'h8000_0280);
    waitIdle();
    chk("R11 err", {31'd0, cmdErr}, 32'd1);
    chk("R11 parked", ctlRdData, 32'h4000_0288);
    chk("R11 writes before", logN, 32'd1);
    chk("R11 no irq", irqN, 32'd0);
    ctlWrite(32'h8000_0290);
    chk("R11 err cleared", {31'd0, cmdErr}, 32'd0);
    waitIdle();
    chk("R11 clean finish", ctlRdData, 32'h4000_0298);
    for (int j = 0; j < 8; j++) begin
      logic [3:0] op;
      case (j)
        0: op = 4'h0; 1: op = 4'h2; 2: op = 4'h4; 3: op = 4'h5;
        4: op = 4'h7; 5: op = 4'hD; 6: op = 4'hE; default: op = 4'hF;
      endcase
      putCmd('h2C0, {op, 28'h000_0010}, 32'd1);
      clearLogs();
      ctlWrite(32'h8000_02C0);
      waitIdle();
      chk("R11 sweep err", {31'd0, cmdErr}, 32'd1);
      chk("R11 sweep ctl", ctlRdData, 32'h4000_02C0);
      chk("R11 sweep quiet", irqN + logN, 32'd0);
    end

    // program E: R10 stop mid-run then resume
    clearLogs();
    ctlWrite(32'h8000_0300);
    repeat (10) @(negedge clk);
    ctlWrite(32'h0000_0000);
    waitIdle();
    begin
      int n;
      n = logN;
      chk("R10 partial run", {31'd0, (n > 0 && n < 8)}, 32'd1);
      chk("R10 stop address", ctlRdData, 32'h4000_0300 + 8 * n);
      repeat (10) @(negedge clk);
      chk("R10 no writes stopped", logN, n);
    end
    ctlWrite(ctlRdData | 32'h8000_0000);
    waitIdle();
    chk("R10 total writes", logN, 32'd8);
    for (int i = 0; i < 8; i++) begin
      chk("R10 seq addr", logA[i], 32'h600 + 4 * i);
      chk("R10 seq data", logD[i], 32'h0101_0101 * (i + 1));
    end
    chk("R10 end ctl", ctlRdData, 32'h4000_0348);

    summary();
    $finish;
  end

endmodule